// File: doc/BRIEF.md
# Flash Sector Access Guard

This block sits between the CPU bus and an on-chip flash array that is divided into equal logical sectors. Each sector owns one bit in a privilege mask and one bit in a space mask. A privilege bit of 1 keeps the sector for supervisor code. A space bit of 1 keeps the sector for data fetches. Every access brings an offset within the flash window, a supervisor/user flag and a data/program flag. The guard takes the sector number from the top bits of that offset and reads both mask bits. A permitted access goes straight to the flash in the same cycle. A refused access never reaches the flash, and the bus cycle ends with a one-cycle transfer error in place of an acknowledge.

The two masks and a control word hold the lock flag. They sit behind a small register port. The masks can always be read, but they accept writes only while the lock is clear. The lock is set by software and is cleared only by reset. While reset is asserted, the masks load their starting values from two configuration words. These words stand for the protection longword kept in the flash array.

Top module: `flash_guard`

## Requirements
- R1: While rstN is low on a clock edge, the privilege mask loads cfgSupWord, the space mask loads cfgDatWord and the lock clears.
- R2: The sector number is the top log2(NUM_SECTORS) bits of accAddr, so with the defaults sector k covers offsets k*32768 to k*32768+32767.
- R3: A user access (accSuper=0) to a sector whose privilege bit is 1 is refused: flashReq stays 0 in that cycle and busErr is 1 in the next cycle.
- R4: A program access (accData=0) to a sector whose space bit is 1 is refused in the same way as R3.
- R5: Any other access with accValid=1 drives flashReq=1 in the same cycle, with flashAddr equal to accAddr and no wait state, and busErr stays 0 in the next cycle.
- R6: An access that breaks both the privilege rule and the space rule gives a single error: busErr is high for one cycle only.
- R7: busErr is never high for two cycles in a row, and busAck always follows flashAck in the same cycle.
- R8: regRdata shows the register picked by regAddr at all times, lock or no lock. Offset 0 is the privilege mask, offset 1 is the space mask, and offset 2 is the control word with the lock in bit 0 and zeros above.
- R9: A write to offset 0 or 1 updates that mask on the next edge when the lock is clear. The write is ignored when the lock is set.
- R10: Writing 1 to bit 0 at offset 2 sets the lock. Once set, the lock stays set until reset, and writing 0 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; loads the configuration words |
| cfgSupWord | input | NUM_SECTORS | Reset value of the privilege mask |
| cfgDatWord | input | NUM_SECTORS | Reset value of the space mask |
| accValid | input | 1 | A CPU access is presented |
| accAddr | input | ADDR_W | Offset of the access within the flash window |
| accSuper | input | 1 | 1 = supervisor access, 0 = user access |
| accData | input | 1 | 1 = data access, 0 = program fetch |
| flashReq | output | 1 | Request forwarded to the flash array (granted access) |
| flashAddr | output | ADDR_W | Offset forwarded to the flash array |
| flashAck | input | 1 | Acknowledge from the flash array |
| busAck | output | 1 | Normal termination to the CPU bus |
| busErr | output | 1 | Transfer-error termination to the CPU bus |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | NUM_SECTORS | Register write data |
| regRdata | output | NUM_SECTORS | Register read data |

## Verification
The bench builds the guard with its default parameters: 32 sectors and a 20-bit window offset. With these values every sector index, including sectors 0 and 31 at the very ends of the window, is reached by random offsets and by directed ones. Using 32 sectors also makes every mask bit and the full width of the register port visible. The two mask reset values are chosen so that all four combinations of privilege and space bits appear across the sectors. This lets single refusals, double refusals and grants happen under every flag setting, both before and after the lock is set.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  // register offsets on the configuration port
  localparam logic [1:0] OFF_SUP = 2'd0;
  localparam logic [1:0] OFF_DAT = 2'd1;
  localparam logic [1:0] OFF_CTL = 2'd2;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrSup;
    logic wrDat;
  } regStrobe_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import flash_guard_pkg::*;
#(
  parameter int NUM_SECTORS = 32,
  parameter int ADDR_W      = 20,
  localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SECTORS-1:0] cfgSupWord,
  input  logic [NUM_SECTORS-1:0] cfgDatWord,
  input  regStrobe_t             strobe,
  input  logic                   lockIn,
  input  logic [1:0]             regAddr,
  input  logic [NUM_SECTORS-1:0] regWdata,
  output logic [NUM_SECTORS-1:0] regRdata,
  input  logic [ADDR_W-1:0]      accAddr,
  output logic                   supBit,
  output logic                   datBit
);
  logic [NUM_SECTORS-1:0] supQ, datQ;
  logic [SEC_W-1:0]       sectorIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supQ <= cfgSupWord;
      datQ <= cfgDatWord;
    end else begin
      if (strobe.wrSup) supQ <= regWdata;
      if (strobe.wrDat) datQ <= regWdata;
    end
  end

  assign sectorIdx = accAddr[ADDR_W-1 -: SEC_W];
  assign supBit    = supQ[sectorIdx];
  assign datBit    = datQ[sectorIdx];

  always_comb begin
    unique case (regAddr)
      OFF_SUP: regRdata = supQ;
      OFF_DAT: regRdata = datQ;
      OFF_CTL: regRdata = {{(NUM_SECTORS-1){1'b0}}, lockIn};
      default: regRdata = '0;
    endcase
  end

  // R9: once locked, neither mask moves
  a_r9_sup_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |=> $stable(supQ));
  a_r9_dat_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |=> $stable(datQ));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic       regWbit0,
  input  logic       accValid,
  input  logic       accSuper,
  input  logic       accData,
  input  logic       supBit,
  input  logic       datBit,
  output regStrobe_t strobe,
  output logic       lockQ,
  output logic       flashReq,
  output logic       busErr
);
  logic denyPriv, denySpace, deny;

  // register write decode, gated by lock
  always_comb begin
    strobe.wrSup = regWr && !lockQ && (regAddr == OFF_SUP);
    strobe.wrDat = regWr && !lockQ && (regAddr == OFF_DAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= 1'b0;
    else if (regWr && regAddr == OFF_CTL && regWbit0) lockQ <= 1'b1;
  end

  // permission check
  assign denyPriv  = !accSuper && supBit;
  assign denySpace = !accData && datBit;
  assign deny      = denyPriv || denySpace;
  assign flashReq  = accValid && !deny;

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= accValid && deny && !busErr;
  end

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);
  a_r5_grant_no_err: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |=> !busErr);
  a_r6_err_after_refusal: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busErr) |-> $past(accValid && !flashReq));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_SECTORS = 32,
  parameter int ADDR_W      = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SECTORS-1:0] cfgSupWord,
  input  logic [NUM_SECTORS-1:0] cfgDatWord,
  input  logic                   accValid,
  input  logic [ADDR_W-1:0]      accAddr,
  input  logic                   accSuper,
  input  logic                   accData,
  output logic                   flashReq,
  output logic [ADDR_W-1:0]      flashAddr,
  input  logic                   flashAck,
  output logic                   busAck,
  output logic                   busErr,
  input  logic                   regWr,
  input  logic [1:0]             regAddr,
  input  logic [NUM_SECTORS-1:0] regWdata,
  output logic [NUM_SECTORS-1:0] regRdata
);
  regStrobe_t strobe;
  logic lock, supBit, datBit;

  guard_datapath #(.NUM_SECTORS(NUM_SECTORS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgSupWord(cfgSupWord), .cfgDatWord(cfgDatWord),
    .strobe(strobe), .lockIn(lock), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .accAddr(accAddr), .supBit(supBit), .datBit(datBit)
  );

  guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWbit0(regWdata[0]), .accValid(accValid), .accSuper(accSuper),
    .accData(accData), .supBit(supBit), .datBit(datBit), .strobe(strobe),
    .lockQ(lock), .flashReq(flashReq), .busErr(busErr)
  );

  assign flashAddr = accAddr;
  assign busAck    = flashAck;
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  localparam int NS = 32;
  localparam int AW = 20;

  logic clk = 0, rstN = 0;
  logic [NS-1:0] cfgSupWord = '0, cfgDatWord = '0;
  logic accValid = 0, accSuper = 0, accData = 0, flashAck = 0, regWr = 0;
  logic [AW-1:0] accAddr = '0;
  logic [1:0] regAddr = '0;
  logic [NS-1:0] regWdata = '0;
  logic flashReq, busAck, busErr;
  logic [AW-1:0] flashAddr;
  logic [NS-1:0] regRdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [NS-1:0] supM, datM;
  logic lockM;

  flash_guard u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic refused(logic [AW-1:0] a, logic s, logic d);
    logic [4:0] sec = a[AW-1 -: 5];
    return (!s && supM[sec]) || (!d && datM[sec]);
  endfunction

  task automatic do_reset(logic [NS-1:0] sw, logic [NS-1:0] dw);
    @(negedge clk);
    rstN = 0; cfgSupWord = sw; cfgDatWord = dw;
    repeat (3) @(negedge clk);
    rstN = 1;
    supM = sw; datM = dw; lockM = 0;
  endtask

  task automatic rd_chk(string req, logic [1:0] off);
    logic [NS-1:0] exp;
    regAddr = off; #1;
    exp = (off == 0) ? supM : (off == 1) ? datM : (off == 2) ? {31'b0, lockM} : '0;
    chk(req, regRdata, exp);
  endtask

  task automatic wr(logic [1:0] off, logic [NS-1:0] v);
    @(negedge clk);
    regWr = 1; regAddr = off; regWdata = v;
    @(negedge clk);
    regWr = 0;
    if (!lockM && off == 0) supM = v;
    if (!lockM && off == 1) datM = v;
    if (off == 2 && v[0]) lockM = 1;
  endtask

  task automatic access(string req, logic [AW-1:0] a, logic s, logic d);
    logic r;
    @(negedge clk);
    accValid = 1; accAddr = a; accSuper = s; accData = d;
    r = refused(a, s, d);
    #1;
    chk({req, " req"}, flashReq, !r);
    if (!r) chk({req, " addr"}, flashAddr, a);
    @(negedge clk);
    accValid = 0;
    chk({req, " err"}, busErr, r);
    @(negedge clk);
    chk({req, " R7 err one cycle"}, busErr, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    do_reset(32'hA5A5_F00F, 32'h0F0F_1234);
    // R1 / R8 reset values and read mux
    rd_chk("R1 sup reset", 0);
    rd_chk("R1 dat reset", 1);
    rd_chk("R1 lock clear", 2);
    rd_chk("R8 unused offset", 3);
    // R2 boundary sectors: sector 0 priv=1, sector 31 priv=1, sector 4 priv=0
    access("R2 R3 sector0 user", 20'h00000, 0, 1);
    access("R2 sector0 end super", 20'h07FFF, 1, 1);
    access("R2 R3 sector31 user", 20'hFFFFF, 0, 1);
    access("R2 sector4 start user", 20'h20000, 0, 1);
    // R4 sector 2 space=1
    access("R4 program fetch", 20'h10000, 1, 0);
    access("R5 data access ok", 20'h10000, 1, 1);
    // R6 sector 2: priv=1 data=1 both fail
    access("R6 double fail", 20'h10004, 0, 0);
    // R7 busAck follows flashAck
    flashAck = 1; #1; chk("R7 ack high", busAck, 1);
    flashAck = 0; #1; chk("R7 ack low", busAck, 0);
    // R9 unlocked writes
    wr(0, 32'h1234_5678); rd_chk("R9 sup write", 0);
    wr(1, 32'h8000_0001); rd_chk("R9 dat write", 1);
    wr(2, 32'h0);         rd_chk("R10 write zero no lock", 2);
    for (int i = 0; i < 150; i++) begin
      if (i % 50 == 0) begin
        wr(0, $urandom); wr(1, $urandom);
      end
      access("R3 R4 R5 random", AW'($urandom), 1'($urandom), 1'($urandom));
    end
    // R10 lock
    wr(2, 32'h1); rd_chk("R10 lock set", 2);
    wr(0, ~supM); rd_chk("R9 locked sup ignored", 0);
    wr(1, ~datM); rd_chk("R9 locked dat ignored", 1);
    wr(2, 32'h0); rd_chk("R10 lock not cleared", 2);
    for (int i = 0; i < 100; i++)
      access("R3 R4 R5 locked random", AW'($urandom), 1'($urandom), 1'($urandom));
    // R1 / R10 reset clears lock and reloads
    do_reset(32'h0000_FFFF, 32'hFFFF_0000);
    rd_chk("R1 R10 reset unlock", 2);
    rd_chk("R1 sup reload", 0);
    rd_chk("R1 dat reload", 1);
    access("R4 high sector fetch", 20'hF8000, 1, 0);
    access("R3 low sector user", 20'h00010, 0, 1);
    access("R5 low sector super fetch", 20'h00010, 1, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule